// File: doc/BRIEF.md
# Bus Address Map Decoder with Region Mirroring

This block sits between a processor's load/store unit and a set of on-chip and external memories. It takes one bus request per cycle (a 32-bit address, an access size, a read/write flag, a debug flag and the address of the instruction being executed). From these it produces a target memory, a local offset inside that memory, and a set of access flags. Only the top eight address bits choose the target. The low bits then go through the fold or mask that the chosen memory needs, so that small memories show up repeated across their whole window.

The flags tell the memory fabric five things: the access must be dropped (a write to a read-only area, a wide write to the byte-only save memory, or an address that hits nothing); the boot ROM is hidden from the current code and a fixed value must be returned instead; which halfword byte lanes a write must drive; and whether a debug read of the I/O window falls past its implemented end and must return zero. Results appear one clock after the request. The memories themselves are not part of the block.

Top module: `mmd_top`

## Requirements
- R1: Address bits 31:24 pick the target, reported as a 4-bit code: 0x00 boot ROM (1), 0x02 external work RAM (2), 0x03 internal work RAM (3), 0x04 I/O (4), 0x05 palette (5), 0x06 video RAM (6), 0x07 object attribute RAM (7), 0x08 to 0x0D program ROM (8), 0x0E save memory (9).
- R2: Offsets are the low 24 address bits with these masks: 14 bits for boot ROM, 18 bits for external work RAM, 15 bits for internal work RAM, 10 bits for palette and attribute RAM, 16 bits for save memory, and no mask for I/O.
- R3: For video RAM, when the low 17 address bits exceed 0x18000, 0x8000 is subtracted from the low 24 bits, and the result is then masked to 17 bits. A value of exactly 0x18000 is left unchanged.
- R4: Program ROM offset is the low 24 bits for even regions 0x08/0x0A/0x0C, and 0x1000000 plus the low 24 bits for odd regions 0x09/0x0B/0x0D.
- R5: Size code 0 is byte, 1 is halfword, and 2 or 3 is word. Halfword accesses clear address bit 0 and word accesses clear bits 1:0 before decoding.
- R6: A write to region 0x00 or to regions 0x08 to 0x0D raises the read-only reject flag and drives no write lanes.
- R7: A halfword or word write to region 0x0E raises the size error flag and drives no write lanes.
- R8: A read of region 0x00 while the instruction address is at or above 0x01000000 raises the protect flag. The protect value is then 0x0000000E for a byte, 0x0000F00E for a halfword and 0xE1B0F00E for a word; otherwise the value is 0.
- R9: The write lane enable (bit 0 = even byte, bit 1 = odd byte) is 2'b11 for halfword/word writes and for byte writes to palette or video RAM. Other accepted byte writes enable only the lane given by address bit 0. Reads drive 2'b00.
- R10: A debug read of the I/O region with address at or above 0x04001000 raises the read-zero flag. Non-debug reads and addresses at or below 0x04000FFF do not raise it.
- R11: Regions 0x01 and 0x0F to 0xFF raise the unmapped flag, give target code 0 and offset 0, and drive no write lanes.
- R12: Outputs are registered: a request accepted at one clock edge appears with out_valid at the next edge. Without a request all outputs are zero, including after synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Bus address |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | 1 for write, 0 for read |
| req_debug | input | 1 | Request comes from the debug path |
| req_pc | input | 32 | Address of the executing instruction |
| out_valid | output | 1 | Registered result valid |
| out_target | output | 4 | Target code (see R1) |
| out_offset | output | 25 | Local offset inside the target |
| out_unmapped | output | 1 | Address hits no region |
| out_ro_reject | output | 1 | Write to read-only region |
| out_size_err | output | 1 | Wide write to save memory |
| out_prot | output | 1 | Boot ROM read is protected |
| out_prot_data | output | 32 | Value to return for a protected read |
| out_lane_en | output | 2 | Halfword byte-lane write enables |
| out_read_zero | output | 1 | Debug I/O read beyond implemented range |

## Verification
The bench first sends one address into each region, together with mirrored copies above each memory's size. This shows whether the mask is applied and whether the mask width is correct. Video RAM gets addresses just below, exactly at and above the 0x18000 fold point, plus an address in the upper mirror of the 128 KiB window; these separate a missing fold, an off-by-one compare and a missing final mask. The same addresses are repeated with different sizes and misaligned low bits, which shows whether alignment happens before decoding. Instruction addresses just below and exactly at the protect limit, combined with every size, separate the three protect values and the boundary compare. Byte writes to even and odd bytes of graphics and non-graphics memory separate lane duplication from single-lane writes.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    localparam int ADDR_W   = 32;
    localparam int OFF_W    = 25;
    localparam int LOW_W    = 24;
    localparam int BIOS_W   = 14;
    localparam int XRAM_W   = 18;
    localparam int IRAM_W   = 15;
    localparam int SMALL_W  = 10;
    localparam int SAVE_W   = 16;
    localparam int VWIN_W   = 17;

    localparam logic [VWIN_W-1:0] VRAM_FOLD_AT  = 17'h18000;
    localparam logic [LOW_W-1:0]  VRAM_FOLD_SUB = 24'h008000;
    localparam logic [ADDR_W-1:0] PROT_LIMIT    = 32'h0100_0000;
    localparam logic [LOW_W-1:0]  IO_LAST       = 24'h000FFF;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef enum logic [3:0] {
        TGT_NONE = 4'd0,
        TGT_BIOS = 4'd1,
        TGT_XRAM = 4'd2,
        TGT_IRAM = 4'd3,
        TGT_IO   = 4'd4,
        TGT_PAL  = 4'd5,
        TGT_VRAM = 4'd6,
        TGT_OAM  = 4'd7,
        TGT_ROM  = 4'd8,
        TGT_SAVE = 4'd9
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [OFF_W-1:0]  off;
        logic              unmapped;
        logic              ro_reject;
        logic              size_err;
        logic              prot;
        logic [31:0]       prot_data;
        logic [1:0]        lane_en;
        logic              read_zero;
    } result_t;

    function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a,
                                                     input logic [1:0] sz);
        logic [ADDR_W-1:0] r;
        r = a;
        if (sz == SZ_HALF)      r[0]   = 1'b0;
        else if (sz != SZ_BYTE) r[1:0] = 2'b00;
        return r;
    endfunction

    function automatic logic [31:0] prot_value(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_000E;
            2'd1:    return 32'h0000_F00E;
            default: return 32'hE1B0_F00E;
        endcase
    endfunction

endpackage

// File: rtl/mmd_region_dec.sv
module mmd_region_dec
    import mmd_pkg::*;
(
    input  logic [7:0] region,
    output tgt_e       tgt,
    output logic       unmapped,
    output logic       ro_region
);
    always_comb begin
        tgt       = TGT_NONE;
        unmapped  = 1'b0;
        ro_region = 1'b0;
        case (region)
            8'h00: begin tgt = TGT_BIOS; ro_region = 1'b1; end
            8'h02: tgt = TGT_XRAM;
            8'h03: tgt = TGT_IRAM;
            8'h04: tgt = TGT_IO;
            8'h05: tgt = TGT_PAL;
            8'h06: tgt = TGT_VRAM;
            8'h07: tgt = TGT_OAM;
            8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: begin
                tgt = TGT_ROM; ro_region = 1'b1;
            end
            8'h0E: tgt = TGT_SAVE;
            default: unmapped = 1'b1;
        endcase
    end
endmodule

// File: rtl/mmd_offset_calc.sv
module mmd_offset_calc
    import mmd_pkg::*;
(
    input  tgt_e              tgt,
    input  logic              rom_hi,
    input  logic [LOW_W-1:0]  low,
    output logic [OFF_W-1:0]  off
);
    logic [LOW_W-1:0] vram_adj;

    always_comb begin
        if (low[VWIN_W-1:0] > VRAM_FOLD_AT) vram_adj = low - VRAM_FOLD_SUB;
        else                                vram_adj = low;
    end

    always_comb begin
        off = '0;
        case (tgt)
            TGT_BIOS: off[BIOS_W-1:0]  = low[BIOS_W-1:0];
            TGT_XRAM: off[XRAM_W-1:0]  = low[XRAM_W-1:0];
            TGT_IRAM: off[IRAM_W-1:0]  = low[IRAM_W-1:0];
            TGT_IO:   off[LOW_W-1:0]   = low;
            TGT_PAL,
            TGT_OAM:  off[SMALL_W-1:0] = low[SMALL_W-1:0];
            TGT_VRAM: off[VWIN_W-1:0]  = vram_adj[VWIN_W-1:0];
            TGT_ROM:  off              = {rom_hi, low};
            TGT_SAVE: off[SAVE_W-1:0]  = low[SAVE_W-1:0];
            default:  off              = '0;
        endcase
    end
endmodule

// File: rtl/mmd_access_ctl.sv
module mmd_access_ctl
    import mmd_pkg::*;
(
    input  tgt_e              tgt,
    input  logic              unmapped,
    input  logic              ro_region,
    input  logic [1:0]        size,
    input  logic              write,
    input  logic              debug,
    input  logic [ADDR_W-1:0] pc,
    input  logic [LOW_W-1:0]  low,
    output logic              ro_reject,
    output logic              size_err,
    output logic              prot,
    output logic [31:0]       prot_data,
    output logic [1:0]        lane_en,
    output logic              read_zero
);
    logic accepted;
    logic graphics;

    always_comb begin
        ro_reject = write && ro_region;
        size_err  = write && (tgt == TGT_SAVE) && (size != SZ_BYTE);
        prot      = !write && (tgt == TGT_BIOS) && (pc >= PROT_LIMIT);
        prot_data = prot ? prot_value(size) : 32'h0;
        read_zero = !write && debug && (tgt == TGT_IO) && (low > IO_LAST);
        accepted  = write && !unmapped && !ro_reject && !size_err;
        graphics  = (tgt == TGT_PAL) || (tgt == TGT_VRAM);
        if (!accepted)                          lane_en = 2'b00;
        else if (size != SZ_BYTE || graphics)   lane_en = 2'b11;
        else                                    lane_en = low[0] ? 2'b10 : 2'b01;
    end
endmodule

// File: rtl/mmd_top.sv
module mmd_top
    import mmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic        req_write,
    input  logic        req_debug,
    input  logic [31:0] req_pc,
    output logic        out_valid,
    output logic [3:0]  out_target,
    output logic [24:0] out_offset,
    output logic        out_unmapped,
    output logic        out_ro_reject,
    output logic        out_size_err,
    output logic        out_prot,
    output logic [31:0] out_prot_data,
    output logic [1:0]  out_lane_en,
    output logic        out_read_zero
);
    logic [ADDR_W-1:0] a;
    tgt_e              tgt;
    logic              unmapped, ro_region;
    result_t           nxt, cur;
    logic              vld_q;

    assign a = align_addr(req_addr, req_size);

    mmd_region_dec u_region (
        .region    (a[31:24]),
        .tgt       (tgt),
        .unmapped  (unmapped),
        .ro_region (ro_region)
    );

    mmd_offset_calc u_offset (
        .tgt    (tgt),
        .rom_hi (a[24]),
        .low    (a[LOW_W-1:0]),
        .off    (nxt.off)
    );

    mmd_access_ctl u_access (
        .tgt       (tgt),
        .unmapped  (unmapped),
        .ro_region (ro_region),
        .size      (req_size),
        .write     (req_write),
        .debug     (req_debug),
        .pc        (req_pc),
        .low       (a[LOW_W-1:0]),
        .ro_reject (nxt.ro_reject),
        .size_err  (nxt.size_err),
        .prot      (nxt.prot),
        .prot_data (nxt.prot_data),
        .lane_en   (nxt.lane_en),
        .read_zero (nxt.read_zero)
    );

    assign nxt.tgt      = tgt;
    assign nxt.unmapped = unmapped;

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            cur   <= nxt;
            vld_q <= 1'b1;
        end
    end

    assign out_valid     = vld_q;
    assign out_target    = cur.tgt;
    assign out_offset    = cur.off;
    assign out_unmapped  = cur.unmapped;
    assign out_ro_reject = cur.ro_reject;
    assign out_size_err  = cur.size_err;
    assign out_prot      = cur.prot;
    assign out_prot_data = cur.prot_data;
    assign out_lane_en   = cur.lane_en;
    assign out_read_zero = cur.read_zero;
endmodule

// File: rtl/mmd_chk.sv
module mmd_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        out_valid,
    input logic [3:0]  out_target,
    input logic [24:0] out_offset,
    input logic        out_unmapped,
    input logic        out_ro_reject,
    input logic        out_size_err,
    input logic        out_prot,
    input logic [31:0] out_prot_data,
    input logic [1:0]  out_lane_en
);
    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);                                        // R12
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && out_target == 4'd0));              // R12
    AST_UNMAPPED_NO_TARGET: assert property (@(posedge clk) disable iff (rst)
        out_unmapped |-> (out_target == 4'd0 && out_offset == 25'd0 && out_lane_en == 2'b00)); // R11
    AST_PROT_ONLY_BOOT: assert property (@(posedge clk) disable iff (rst)
        out_prot |-> (out_target == 4'd1 && out_prot_data[7:0] == 8'h0E)); // R8
    AST_RO_NO_LANES: assert property (@(posedge clk) disable iff (rst)
        (out_ro_reject || out_size_err) |-> out_lane_en == 2'b00);       // R6
    AST_VRAM_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (out_target == 4'd6) |-> out_offset <= 25'h18000);               // R3
endmodule

bind mmd_top mmd_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .out_valid     (out_valid),
    .out_target    (out_target),
    .out_offset    (out_offset),
    .out_unmapped  (out_unmapped),
    .out_ro_reject (out_ro_reject),
    .out_size_err  (out_size_err),
    .out_prot      (out_prot),
    .out_prot_data (out_prot_data),
    .out_lane_en   (out_lane_en)
);

// File: tb/tb_mmd_top.sv
module tb_mmd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_debug = 1'b0;
    logic [31:0] req_pc = '0;
    logic        out_valid;
    logic [3:0]  out_target;
    logic [24:0] out_offset;
    logic        out_unmapped, out_ro_reject, out_size_err, out_prot, out_read_zero;
    logic [31:0] out_prot_data;
    logic [1:0]  out_lane_en;

    always #2 clk = ~clk;

    mmd_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_debug(req_debug),
        .req_pc(req_pc), .out_valid(out_valid), .out_target(out_target),
        .out_offset(out_offset), .out_unmapped(out_unmapped),
        .out_ro_reject(out_ro_reject), .out_size_err(out_size_err),
        .out_prot(out_prot), .out_prot_data(out_prot_data),
        .out_lane_en(out_lane_en), .out_read_zero(out_read_zero)
    );

    // expected item: {target, offset, flags{unm,ro,serr,prot,zero}, pdata, lanes}
    typedef struct packed {
        logic [3:0]  tgt;
        logic [24:0] off;
        logic [4:0]  flg;
        logic [31:0] pd;
        logic [1:0]  ln;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] addr, input logic [1:0] sz,
                         input logic wr, input logic dbg, input logic [31:0] pc,
                         input logic [3:0] tgt, input logic [24:0] off,
                         input logic [4:0] flg, input logic [31:0] pd,
                         input logic [1:0] ln, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_size = sz;
        req_write = wr;   req_debug = dbg; req_pc = pc;
        e.tgt = tgt; e.off = off; e.flg = flg; e.pd = pd; e.ln = ln;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // monitor: compare whenever a registered result shows up
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                check("R12", "unexpected valid", 64'd1, 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check(t, "target", {60'd0, out_target}, {60'd0, e.tgt});
                check(t, "offset", {39'd0, out_offset}, {39'd0, e.off});
                check(t, "flags", {59'd0, out_unmapped, out_ro_reject, out_size_err, out_prot, out_read_zero},
                      {59'd0, e.flg});
                check(t, "prot_data", {32'd0, out_prot_data}, {32'd0, e.pd});
                check(t, "lanes", {62'd0, out_lane_en}, {62'd0, e.ln});
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [31:0] PCLO = 32'h0000_0100;
    localparam logic [31:0] PCHI = 32'h0800_0000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12", "reset valid", {63'd0, out_valid}, 64'd0);
        check("R12", "reset target", {60'd0, out_target}, 64'd0);
        rst = 1'b0;

        // R1 / R2 region and mirror masks
        drive(32'h0000_1234, 2'd0, 0, 0, PCLO, 4'd1, 25'h1234, 5'b0, 0, 2'b00, "R1");
        drive(32'h0000_5234, 2'd0, 0, 0, PCLO, 4'd1, 25'h1234, 5'b0, 0, 2'b00, "R2");
        drive(32'h0204_1003, 2'd2, 0, 0, PCLO, 4'd2, 25'h01000, 5'b0, 0, 2'b00, "R5");
        drive(32'h03FF_8001, 2'd1, 0, 0, PCLO, 4'd3, 25'h0, 5'b0, 0, 2'b00, "R2");
        drive(32'h0500_0C22, 2'd1, 0, 0, PCLO, 4'd5, 25'h022, 5'b0, 0, 2'b00, "R2");
        drive(32'h0700_07FE, 2'd1, 0, 0, PCLO, 4'd7, 25'h3FE, 5'b0, 0, 2'b00, "R2");
        drive(32'h0E12_3456, 2'd0, 0, 0, PCLO, 4'd9, 25'h3456, 5'b0, 0, 2'b00, "R2");
        drive(32'h0412_3456, 2'd0, 0, 0, PCLO, 4'd4, 25'h123456, 5'b0, 0, 2'b00, "R1");
        idle(2);
        // R3 video fold
        drive(32'h0601_8000, 2'd1, 0, 0, PCLO, 4'd6, 25'h18000, 5'b0, 0, 2'b00, "R3");
        drive(32'h0601_8002, 2'd1, 0, 0, PCLO, 4'd6, 25'h10002, 5'b0, 0, 2'b00, "R3");
        drive(32'h0603_7FFE, 2'd2, 0, 0, PCLO, 4'd6, 25'h17FFC, 5'b0, 0, 2'b00, "R3");
        drive(32'h0603_A000, 2'd2, 0, 0, PCLO, 4'd6, 25'h12000, 5'b0, 0, 2'b00, "R3");
        drive(32'h0602_0004, 2'd2, 0, 0, PCLO, 4'd6, 25'h4, 5'b0, 0, 2'b00, "R3");
        // R4 program ROM halves
        drive(32'h0812_3456, 2'd1, 0, 0, PCLO, 4'd8, 25'h0123456, 5'b0, 0, 2'b00, "R4");
        drive(32'h0D00_0010, 2'd0, 0, 0, PCLO, 4'd8, 25'h1000010, 5'b0, 0, 2'b00, "R4");
        drive(32'h0BFF_FFFF, 2'd3, 0, 0, PCLO, 4'd8, 25'h1FFFFFC, 5'b0, 0, 2'b00, "R4");
        drive(32'h0A00_0003, 2'd1, 0, 0, PCLO, 4'd8, 25'h0000002, 5'b0, 0, 2'b00, "R5");
        // R9 lanes
        drive(32'h0500_0401, 2'd0, 1, 0, PCLO, 4'd5, 25'h001, 5'b0, 0, 2'b11, "R9");
        drive(32'h0600_0011, 2'd0, 1, 0, PCLO, 4'd6, 25'h011, 5'b0, 0, 2'b11, "R9");
        drive(32'h0700_0403, 2'd0, 1, 0, PCLO, 4'd7, 25'h003, 5'b0, 0, 2'b10, "R9");
        drive(32'h0200_0000, 2'd0, 1, 0, PCLO, 4'd2, 25'h0, 5'b0, 0, 2'b01, "R9");
        drive(32'h0300_0007, 2'd2, 1, 0, PCLO, 4'd3, 25'h4, 5'b0, 0, 2'b11, "R9");
        // R6 read-only, R7 save width
        drive(32'h0900_0000, 2'd1, 1, 0, PCLO, 4'd8, 25'h1000000, 5'b01000, 0, 2'b00, "R6");
        drive(32'h0000_0010, 2'd0, 1, 0, PCHI, 4'd1, 25'h10, 5'b01000, 0, 2'b00, "R6");
        drive(32'h0E00_0100, 2'd1, 1, 0, PCLO, 4'd9, 25'h100, 5'b00100, 0, 2'b00, "R7");
        drive(32'h0E00_0202, 2'd2, 1, 0, PCLO, 4'd9, 25'h200, 5'b00100, 0, 2'b00, "R7");
        drive(32'h0E00_5555, 2'd0, 1, 0, PCLO, 4'd9, 25'h5555, 5'b0, 0, 2'b10, "R7");
        idle(1);
        // R8 protection
        drive(32'h0000_0000, 2'd0, 0, 0, PCHI, 4'd1, 25'h0, 5'b00010, 32'h0000000E, 2'b00, "R8");
        drive(32'h0000_0002, 2'd1, 0, 0, PCHI, 4'd1, 25'h2, 5'b00010, 32'h0000F00E, 2'b00, "R8");
        drive(32'h0000_0004, 2'd2, 0, 0, PCHI, 4'd1, 25'h4, 5'b00010, 32'hE1B0F00E, 2'b00, "R8");
        drive(32'h0000_0004, 2'd2, 0, 0, 32'h00FF_FFFF, 4'd1, 25'h4, 5'b0, 0, 2'b00, "R8");
        drive(32'h0000_0008, 2'd2, 0, 0, 32'h0100_0000, 4'd1, 25'h8, 5'b00010, 32'hE1B0F00E, 2'b00, "R8");
        // R10 debug I/O
        drive(32'h0400_1000, 2'd0, 0, 1, PCLO, 4'd4, 25'h1000, 5'b00001, 0, 2'b00, "R10");
        drive(32'h0400_0FFF, 2'd0, 0, 1, PCLO, 4'd4, 25'h0FFF, 5'b0, 0, 2'b00, "R10");
        drive(32'h0400_2000, 2'd0, 0, 0, PCLO, 4'd4, 25'h2000, 5'b0, 0, 2'b00, "R10");
        // R11 unmapped
        drive(32'h0100_0000, 2'd0, 0, 0, PCLO, 4'd0, 25'h0, 5'b10000, 0, 2'b00, "R11");
        drive(32'hF000_1234, 2'd2, 0, 0, PCLO, 4'd0, 25'h0, 5'b10000, 0, 2'b00, "R11");
        drive(32'h1000_0000, 2'd0, 1, 0, PCLO, 4'd0, 25'h0, 5'b10000, 0, 2'b00, "R11");
        drive(32'h0F00_0000, 2'd1, 1, 0, PCLO, 4'd0, 25'h0, 5'b10000, 0, 2'b00, "R11");
        idle(3);
        // R12 all results drained, idle output cleared
        check("R12", "pending results", {32'd0, expq.size()}, 64'd0);
        check("R12", "idle valid", {63'd0, out_valid}, 64'd0);
        check("R12", "idle lanes", {62'd0, out_lane_en}, 64'd0);
        finish_run();
    end
endmodule